// File: doc/BRIEF.md
# Snapshot-Latched Packet Statistics Counters

This block watches a transmit and a receive packet stream and keeps 64-bit event totals. On transmit it counts start-of-packet and end-of-packet beats. On receive it counts the same two events, plus packets whose end-of-packet beat carries an error flag. A beat counts only while its valid strobe is high. Software reads each total as two 32-bit halves through a small memory-mapped register port. Read data appears one cycle after the read strobe.

A 64-bit value read as two halves can tear while traffic keeps running. To prevent this, software sets a snapshot bit in the control register. The 0-to-1 transition copies every live counter into a shadow copy in one cycle. While the bit stays set, reads return the frozen copy and the live counters keep counting. Clearing the bit returns reads to the live values. A self-clearing clear bit in the same register zeroes both the live and the shadow counters. Software uses it after traffic has stopped, so that a following run can be compared on both sides.

Top module: `pkt_stat_top`

## Requirements
- R1: After reset, every counter offset and the control register at 0x00 read as zero.
- R2: A transmit beat with tx_valid_i and tx_sop_i high adds one to the transmit start count. Its low half reads at 0x20 and its high half at 0x24. A transmit beat with tx_valid_i and tx_eop_i high adds one to the transmit end count, read at 0x28 (low) and 0x2C (high).
- R3: A receive beat with rx_valid_i and rx_sop_i high adds one to the receive start count, read at 0x38 (low) and 0x3C (high). A receive beat with rx_valid_i and rx_eop_i high adds one to the receive end count, read at 0x40 (low) and 0x44 (high).
- R4: The receive error count, read at 0x48 (low) and 0x4C (high), adds one only for a valid beat that has both rx_eop_i and rx_err_i high. An error flag on a beat that is not an end-of-packet beat is not counted.
- R5: A write to 0x00 with bit 6 at 1, made while the snapshot bit is 0, copies every live counter into the shadow copy. The values copied are those from before that write's clock edge. While bit 6 stays at 1, counter reads return the shadow copy unchanged.
- R6: Live counters keep counting while the snapshot bit is 1. After a write of 0 to bit 6, counter reads return the live values again.
- R7: While the snapshot bit is 0, a counter read returns the live value as it stood before the clock edge of the read strobe. Events in that same cycle do not show in that read.
- R8: A write to 0x00 with bit 0 at 1 zeroes all live and shadow counters at its clock edge. Events in the cycle of that write are dropped. The clear takes priority over a capture in the same write. Bit 0 always reads back as 0.
- R9: Reading 0x00 returns the snapshot bit at bit 6, with all other bits zero. Reads of unmapped offsets return zero. Writes to counter offsets have no effect.
- R10: csr_rdata_o is updated at the clock edge of a read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit beat valid |
| tx_sop_i | input | 1 | Transmit start-of-packet marker |
| tx_eop_i | input | 1 | Transmit end-of-packet marker |
| rx_valid_i | input | 1 | Receive beat valid |
| rx_sop_i | input | 1 | Receive start-of-packet marker |
| rx_eop_i | input | 1 | Receive end-of-packet marker |
| rx_err_i | input | 1 | Receive error flag |
| csr_wr_i | input | 1 | Register write strobe |
| csr_rd_i | input | 1 | Register read strobe |
| csr_addr_i | input | 8 | Register byte offset |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data, valid the cycle after csr_rd_i |

## Verification
The hardest situations to reach are collisions on a single clock edge. One is a snapshot capture, a clear, or a read landing in the same cycle as packet events. The other is a low-half and high-half pair read while the snapshot bit holds and traffic keeps moving. Directed cases place a capture write and a clear write exactly on cycles with active start markers. Long random runs mix traffic every cycle with snapshot toggles, rare clears, writes to read-only offsets, and reads of mapped and unmapped offsets. A bench model that applies each edge's rules in order predicts every read.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  localparam int NUM_CNT  = 5;
  localparam int CNT_W    = 64;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int HALVES   = CNT_W / DATA_W;
  localparam int HALF_OFS = DATA_W / 8;
  localparam int SNAP_BIT = 6;
  localparam int CLR_BIT  = 0;
  localparam logic [ADDR_W-1:0] CTRL_OFS = '0;

  typedef enum int {
    EV_TX_SOP = 0,
    EV_TX_EOP = 1,
    EV_RX_SOP = 2,
    EV_RX_EOP = 3,
    EV_RX_ERR = 4
  } ev_e;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic logic [ADDR_W-1:0] cnt_base(input int idx);
    case (idx)
      EV_TX_SOP: return ADDR_W'(8'h20);
      EV_TX_EOP: return ADDR_W'(8'h28);
      EV_RX_SOP: return ADDR_W'(8'h38);
      EV_RX_EOP: return ADDR_W'(8'h40);
      default:   return ADDR_W'(8'h48);
    endcase
  endfunction
endpackage

// File: rtl/pstat_evt.sv
module pstat_evt
  import pstat_pkg::*;
(
  input  logic               tx_valid_i,
  input  logic               tx_sop_i,
  input  logic               tx_eop_i,
  input  logic               rx_valid_i,
  input  logic               rx_sop_i,
  input  logic               rx_eop_i,
  input  logic               rx_err_i,
  output logic [NUM_CNT-1:0] evt_o
);
  always_comb begin
    evt_o            = '0;
    evt_o[EV_TX_SOP] = tx_valid_i & tx_sop_i;
    evt_o[EV_TX_EOP] = tx_valid_i & tx_eop_i;
    evt_o[EV_RX_SOP] = rx_valid_i & rx_sop_i;
    evt_o[EV_RX_EOP] = rx_valid_i & rx_eop_i;
    // error counted once per packet, on its closing beat
    evt_o[EV_RX_ERR] = rx_valid_i & rx_eop_i & rx_err_i;
  end
endmodule

// File: rtl/pstat_cnt.sv
module pstat_cnt #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         cap_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_o   <= '0;
      shadow_o <= '0;
    end else if (clr_i) begin
      live_o   <= '0;
      shadow_o <= '0;
    end else begin
      if (cap_i) shadow_o <= live_o;
      if (inc_i) live_o <= live_o + W'(1);
    end
  end
endmodule

// File: rtl/pstat_csr.sv
module pstat_csr
  import pstat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  cnt_t              live_i   [NUM_CNT],
  input  cnt_t              shadow_i [NUM_CNT],
  output logic              clr_o,
  output logic              cap_o,
  output logic              snap_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              ctrl_wr;
  logic              snap_q;
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr = wr_i && (addr_i == CTRL_OFS);
  assign clr_o   = ctrl_wr && wdata_i[CLR_BIT];
  assign cap_o   = ctrl_wr && wdata_i[SNAP_BIT] && !snap_q;
  assign snap_o  = snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= 1'b0;
    else if (ctrl_wr) snap_q <= wdata_i[SNAP_BIT];
  end

  always_comb begin
    rd_nxt = '0;
    if (addr_i == CTRL_OFS) rd_nxt[SNAP_BIT] = snap_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      for (int h = 0; h < HALVES; h++) begin
        if (addr_i == cnt_base(i) + ADDR_W'(h * HALF_OFS)) begin
          rd_nxt = snap_q ? shadow_i[i][h*DATA_W +: DATA_W]
                          : live_i[i][h*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/pkt_stat_top.sv
module pkt_stat_top
  import pstat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic              tx_sop_i,
  input  logic              tx_eop_i,
  input  logic              rx_valid_i,
  input  logic              rx_sop_i,
  input  logic              rx_eop_i,
  input  logic              rx_err_i,
  input  logic              csr_wr_i,
  input  logic              csr_rd_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o
);
  logic [NUM_CNT-1:0] evt;
  logic               clr;
  logic               cap;
  logic               snap;
  cnt_t               cnt_live   [NUM_CNT];
  cnt_t               cnt_shadow [NUM_CNT];

  pstat_evt u_evt (
    .tx_valid_i (tx_valid_i),
    .tx_sop_i   (tx_sop_i),
    .tx_eop_i   (tx_eop_i),
    .rx_valid_i (rx_valid_i),
    .rx_sop_i   (rx_sop_i),
    .rx_eop_i   (rx_eop_i),
    .rx_err_i   (rx_err_i),
    .evt_o      (evt)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    pstat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (evt[g]),
      .clr_i    (clr),
      .cap_i    (cap),
      .live_o   (cnt_live[g]),
      .shadow_o (cnt_shadow[g])
    );
  end

  pstat_csr u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (csr_wr_i),
    .rd_i     (csr_rd_i),
    .addr_i   (csr_addr_i),
    .wdata_i  (csr_wdata_i),
    .live_i   (cnt_live),
    .shadow_i (cnt_shadow),
    .clr_o    (clr),
    .cap_o    (cap),
    .snap_o   (snap),
    .rdata_o  (csr_rdata_o)
  );
endmodule

// File: rtl/pstat_chk.sv
module pstat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_valid_i,
  input logic        tx_sop_i,
  input logic        rx_valid_i,
  input logic        rx_eop_i,
  input logic        rx_err_i,
  input logic        csr_rd_i,
  input logic [7:0]  csr_addr_i,
  input logic [31:0] csr_rdata_o,
  input logic        clr_i,
  input logic        cap_i,
  input logic        snap_i,
  input logic [63:0] live_sop_i,
  input logic [63:0] shadow_sop_i,
  input logic [63:0] live_err_i
);
  a_r2_tx_sop_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_sop_i && !clr_i) |=> (live_sop_i == $past(live_sop_i) + 64'd1));

  a_r4_err_only_on_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rx_valid_i && rx_eop_i && rx_err_i) && !clr_i) |=> $stable(live_err_i));

  a_r5_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !clr_i) |=> $stable(shadow_sop_i));

  a_r5_cap_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !snap_i);

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (live_sop_i == 64'd0 && shadow_sop_i == 64'd0 && live_err_i == 64'd0));

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && csr_addr_i >= 8'h50) |=> (csr_rdata_o == 32'd0));

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_rd_i |=> $stable(csr_rdata_o));
endmodule

bind pkt_stat_top pstat_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_valid_i   (tx_valid_i),
  .tx_sop_i     (tx_sop_i),
  .rx_valid_i   (rx_valid_i),
  .rx_eop_i     (rx_eop_i),
  .rx_err_i     (rx_err_i),
  .csr_rd_i     (csr_rd_i),
  .csr_addr_i   (csr_addr_i),
  .csr_rdata_o  (csr_rdata_o),
  .clr_i        (clr),
  .cap_i        (cap),
  .snap_i       (snap),
  .live_sop_i   (cnt_live[0]),
  .shadow_sop_i (cnt_shadow[0]),
  .live_err_i   (cnt_live[4])
);

// File: tb/pkt_stat_top_tb.sv
module pkt_stat_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_valid_i = 0, tx_sop_i = 0, tx_eop_i = 0;
  logic        rx_valid_i = 0, rx_sop_i = 0, rx_eop_i = 0, rx_err_i = 0;
  logic        csr_wr_i = 0, csr_rd_i = 0;
  logic [7:0]  csr_addr_i = 0;
  logic [31:0] csr_wdata_i = 0;
  logic [31:0] csr_rdata_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string force_tag = "";

  logic [63:0] m_live [5];
  logic [63:0] m_shad [5];
  bit          m_snap;

  pkt_stat_top u_dut (.*);

  always #4 clk_i = ~clk_i;

  function automatic int idx_of(input logic [7:0] a);
    case (a)
      8'h20, 8'h24: return 0;
      8'h28, 8'h2C: return 1;
      8'h38, 8'h3C: return 2;
      8'h40, 8'h44: return 3;
      8'h48, 8'h4C: return 4;
      default:      return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int i;
    logic [63:0] v;
    if (a == 8'h00) return {25'd0, m_snap, 6'd0};
    i = idx_of(a);
    if (i < 0) return 32'd0;
    v = m_snap ? m_shad[i] : m_live[i];
    return a[2] ? v[63:32] : v[31:0];
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    int i;
    i = idx_of(a);
    if (force_tag != "") return force_tag;
    if (i < 0) return "R9";
    if (m_snap) return "R5";
    if (i < 2) return "R2";
    if (i < 4) return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; model applied at the edge; read checked after
  task automatic step();
    logic [31:0] exp;
    string tg;
    bit rd, ctrl_wr, clr, cap;
    logic [4:0] ev;
    rd  = csr_rd_i;
    exp = exp_read(csr_addr_i);
    tg  = tag_of(csr_addr_i);
    ctrl_wr = csr_wr_i && csr_addr_i == 8'h00;
    clr = ctrl_wr && csr_wdata_i[0];
    cap = ctrl_wr && csr_wdata_i[6] && !m_snap;
    ev  = {rx_valid_i & rx_eop_i & rx_err_i, rx_valid_i & rx_eop_i,
           rx_valid_i & rx_sop_i, tx_valid_i & tx_eop_i, tx_valid_i & tx_sop_i};
    @(posedge clk_i);
    for (int i = 0; i < 5; i++) begin
      if (clr) begin
        m_live[i] = 0; m_shad[i] = 0;
      end else begin
        if (cap) m_shad[i] = m_live[i];
        if (ev[i]) m_live[i] = m_live[i] + 64'd1;
      end
    end
    if (ctrl_wr) m_snap = csr_wdata_i[6];
    @(negedge clk_i);
    if (rd) check(tg, csr_rdata_o, exp);
    {tx_valid_i, tx_sop_i, tx_eop_i} = 0;
    {rx_valid_i, rx_sop_i, rx_eop_i, rx_err_i} = 0;
    csr_wr_i = 0; csr_rd_i = 0; csr_wdata_i = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    csr_rd_i = 1; csr_addr_i = a; step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    csr_wr_i = 1; csr_addr_i = a; csr_wdata_i = d; step();
  endtask

  task automatic read_all();
    logic [7:0] offs [10] = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h38,
                              8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C};
    for (int k = 0; k < 10; k++) rd(offs[k]);
  endtask

  task automatic pkt(input bit tx, input bit rx, input bit err_mid, input bit err_end);
    for (int b = 0; b < 3; b++) begin
      tx_valid_i = tx; tx_sop_i = (b == 0); tx_eop_i = (b == 2);
      rx_valid_i = rx; rx_sop_i = (b == 0); rx_eop_i = (b == 2);
      rx_err_i = (b == 1) ? err_mid : (b == 2) ? err_end : 1'b0;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rnd_offs [14] = '{8'h00, 8'h04, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30,
                                  8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h54};
    logic [31:0] held;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 5; i++) begin m_live[i] = 0; m_shad[i] = 0; end
    m_snap = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // reset state
    force_tag = "R1";
    rd(8'h00);
    read_all();
    force_tag = "";

    // 16-packet run; error flag mid-packet ignored, on closing beat counted
    for (int p = 0; p < 16; p++) pkt(1, 1, p == 3, p == 7 || p == 11);
    rd(8'h20); check("R2", csr_rdata_o, 32'd16);
    rd(8'h38); check("R3", csr_rdata_o, 32'd16);
    rd(8'h40); check("R3", csr_rdata_o, 32'd16);
    rd(8'h48); check("R4", csr_rdata_o, 32'd2);

    // read in a cycle with an event returns the pre-edge value
    force_tag = "R7";
    tx_valid_i = 1; tx_sop_i = 1; rd(8'h20);
    rd(8'h20);
    force_tag = "";

    // capture on the same edge as a start event
    tx_valid_i = 1; tx_sop_i = 1; wr(8'h00, 32'h40);
    force_tag = "R9"; rd(8'h00); force_tag = "";
    for (int p = 0; p < 5; p++) pkt(1, 1, 0, 1);
    force_tag = "R5"; read_all(); force_tag = "";
    wr(8'h00, 32'h40); // still set: no new capture
    force_tag = "R5"; rd(8'h20); force_tag = "";
    wr(8'h00, 32'h0);
    force_tag = "R6"; read_all(); force_tag = "";

    // writes to counter offsets ignored, unmapped offsets zero
    force_tag = "R9";
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h4C, 32'h1234_5678);
    rd(8'h20); rd(8'h4C); rd(8'h30); rd(8'h04); rd(8'h50);
    force_tag = "";

    // read data holds between reads
    rd(8'h28); held = csr_rdata_o;
    pkt(1, 1, 0, 0);
    check("R10", csr_rdata_o, held);

    // clear with capture and events on the same edge
    wr(8'h00, 32'h0);
    tx_valid_i = 1; tx_sop_i = 1; rx_valid_i = 1; rx_eop_i = 1; rx_err_i = 1;
    wr(8'h00, 32'h41);
    force_tag = "R8"; read_all(); rd(8'h00); force_tag = "";
    wr(8'h00, 32'h0);
    force_tag = "R8"; read_all(); force_tag = "";

    // random mix
    for (int c = 0; c < 6000; c++) begin
      int r;
      r = $urandom % 100;
      tx_valid_i = $urandom; tx_sop_i = $urandom; tx_eop_i = $urandom;
      rx_valid_i = $urandom; rx_sop_i = $urandom; rx_eop_i = $urandom;
      rx_err_i = $urandom;
      if (r < 2) begin
        csr_wr_i = 1; csr_addr_i = 8'h00; csr_wdata_i = $urandom | 32'h1;
      end else if (r < 10) begin
        csr_wr_i = 1; csr_addr_i = 8'h00; csr_wdata_i = $urandom & 32'hFFFF_FFFE;
      end else if (r < 15) begin
        csr_wr_i = 1; csr_addr_i = rnd_offs[2 + $urandom % 11]; csr_wdata_i = $urandom;
        if (csr_addr_i == 8'h00) csr_addr_i = 8'h20;
      end else if (r < 65) begin
        csr_rd_i = 1; csr_addr_i = rnd_offs[$urandom % 14];
      end
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule